// File: doc/BRIEF.md
# Dual-Mode Clock Gate Controller

This block owns a single clock gate and its 32-bit control word. The gate is built as one of five kinds, fixed at elaboration: absent, hardware-only, software-only, selectable, or hardware-or-open. An idle-detection circuit next to the gated logic raises `auto_req` while it needs the clock. Software writes the control word to open or close the gate, or to hand control to that request. The block produces a level enable, a glitch-free gated clock, and a status bit that follows the enable after a fixed delay.

Software changes the gate by writing the control word. It then reads the word back until the status bit matches the state it asked for. The hardware/software choice is made per gate inside the control word, so no separate mode register is needed.

Top module: `dual_gate_ctrl`

## Requirements
- R1: Read layout of the control word: bit 0 is status (read-only), bit 1 is the software enable, and bit 2 is the control select, where 1 means hardware control. All other bits read 0. A bit that the gate kind does not implement reads 0, except the select bit of a hardware-only gate, which reads 1.
- R2: After reset, every gate with a writable enable has enable = 1. Every gate with a writable select has select = 0, which is software control. Status reads 1 for every kind except hardware-only, where it reads 0.
- R3: An absent gate holds `gate_en` at 1 at all times. Writes change nothing in its read value.
- R4: A hardware-only gate drives `gate_en` equal to `auto_req`. Writes do not change its read value.
- R5: A software-only gate drives `gate_en` from the stored enable bit and ignores `auto_req`. Its select bit cannot be written and reads 0.
- R6: A selectable gate drives `gate_en` from `auto_req` when select = 1, and from the stored enable bit when select = 0.
- R7: A hardware-or-open gate drives `gate_en` from `auto_req` when select = 1, and holds it at 1 when select = 0. It has no enable bit, so bit 1 reads 0.
- R8: The status bit equals the value of `gate_en` sampled two rising clock edges earlier.
- R9: `gated_clk` is `clk` ANDed with a copy of the enable that a latch captures while `clk` is low. While `clk` is high, the gated clock keeps the enable value from the end of the low phase, even if `gate_en` changes.
- R10: A write with `reg_wr` high takes effect at the next rising edge. Before that edge `gate_en` keeps its old value; after it, `gate_en` reflects the new bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read value of the control word |
| auto_req | input | 1 | Clock request from local idle logic |
| gate_en | output | 1 | Effective gate enable (level) |
| gate_status | output | 1 | Settled gate state, delayed copy of gate_en |
| gated_clk | output | 1 | Glitch-free gated clock |

## Verification
A wrong stored enable or select shows on `gate_en` and in the read value one cycle after the write that should have set it. A wrong delay in the status chain shows on `gate_status` exactly two edges after any change of `gate_en`. A faulty latch shows on `gated_clk` in the high phase where `auto_req` toggles. Each cycle the bench compares all five gate kinds against its own model, so any mode that takes a wrong decision is seen within a cycle.

// File: rtl/gcg_pkg.sv
package gcg_pkg;

  typedef enum logic [2:0] {
    GK_NONE       = 3'd0,
    GK_HW_ONLY    = 3'd1,
    GK_SW_ONLY    = 3'd2,
    GK_SELECTABLE = 3'd3,
    GK_HW_OR_ON   = 3'd4
  } gate_kind_e;

  // kind has a writable software enable bit
  function automatic logic has_en_bit(gate_kind_e k);
    return (k == GK_SW_ONLY) || (k == GK_SELECTABLE);
  endfunction

  // kind has a writable control select bit
  function automatic logic has_sel_bit(gate_kind_e k);
    return (k == GK_SELECTABLE) || (k == GK_HW_OR_ON);
  endfunction

  // hardware auto-gating currently in charge
  function automatic logic hw_in_control(gate_kind_e k, logic sel);
    case (k)
      GK_HW_ONLY:                 return 1'b1;
      GK_SELECTABLE, GK_HW_OR_ON: return sel;
      default:                    return 1'b0;
    endcase
  endfunction

  // effective enable of the gate
  function automatic logic gate_open(gate_kind_e k, logic en, logic sel, logic req);
    case (k)
      GK_NONE:       return 1'b1;
      GK_HW_ONLY:    return req;
      GK_SW_ONLY:    return en;
      GK_SELECTABLE: return sel ? req : en;
      GK_HW_OR_ON:   return sel ? req : 1'b1;
      default:       return 1'b1;
    endcase
  endfunction

  // reset value of the settled status
  function automatic logic status_reset(gate_kind_e k);
    return (k == GK_HW_ONLY) ? 1'b0 : 1'b1;
  endfunction

endpackage

// File: rtl/gcg_ctrl_reg.sv
module gcg_ctrl_reg #(
  parameter gcg_pkg::gate_kind_e KIND = gcg_pkg::GK_SELECTABLE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wr_en_bit,
  input  logic wr_sel_bit,
  output logic en_q,
  output logic sel_q
);
  import gcg_pkg::*;

  localparam logic HAS_EN  = has_en_bit(KIND);
  localparam logic HAS_SEL = has_sel_bit(KIND);
  localparam logic SEL_FIX = (KIND == GK_HW_ONLY);

  generate
    if (HAS_EN) begin : g_en
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  en_q <= 1'b1;
        else if (wr) en_q <= wr_en_bit;
      end
    end else begin : g_no_en
      logic en_unused;
      assign en_unused = wr_en_bit;
      assign en_q = 1'b0;
    end

    if (HAS_SEL) begin : g_sel
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  sel_q <= 1'b0;
        else if (wr) sel_q <= wr_sel_bit;
      end
    end else begin : g_no_sel
      logic sel_unused;
      assign sel_unused = wr_sel_bit;
      assign sel_q = SEL_FIX;
    end

    if (!HAS_EN && !HAS_SEL) begin : g_no_wr
      logic wr_unused;
      assign wr_unused = wr;
    end
  endgenerate

endmodule

// File: rtl/gcg_status_sync.sv
module gcg_status_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      logic [1:0] age;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            age <= 2'd0;
        else if (age != 2'd2)  age <= age + 2'd1;
      end
      AST_STATUS_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (q == $past(d, 2))); // R8
    end
  endgenerate

endmodule

// File: rtl/gcg_latch_gate.sv
module gcg_latch_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en_in,
  output logic en_latched,
  output logic gated_clk
);
  always_latch begin
    if (!clk) en_latched = en_in;
  end

  assign gated_clk = clk & en_latched;

  AST_LATCH_OPEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    en_latched == en_in); // R9

endmodule

// File: rtl/dual_gate_ctrl.sv
module dual_gate_ctrl #(
  parameter gcg_pkg::gate_kind_e KIND = gcg_pkg::GK_SELECTABLE,
  parameter int DATA_W      = 32,
  parameter int STAT_BIT    = 0,
  parameter int EN_BIT      = 1,
  parameter int SEL_BIT     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              auto_req,
  output logic              gate_en,
  output logic              gate_status,
  output logic              gated_clk
);
  import gcg_pkg::*;

  localparam logic RST_STATUS = status_reset(KIND);
  localparam logic [DATA_W-1:0] USED_MASK =
    (DATA_W'(1) << STAT_BIT) | (DATA_W'(1) << EN_BIT) | (DATA_W'(1) << SEL_BIT);

  logic en_q, sel_q, hw_ctl, en_latched;
  logic wdata_unused;

  assign wdata_unused = ^reg_wdata;

  gcg_ctrl_reg #(.KIND(KIND)) u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (reg_wr),
    .wr_en_bit  (reg_wdata[EN_BIT]),
    .wr_sel_bit (reg_wdata[SEL_BIT]),
    .en_q       (en_q),
    .sel_q      (sel_q)
  );

  assign hw_ctl  = hw_in_control(KIND, sel_q);
  assign gate_en = gate_open(KIND, en_q, sel_q, auto_req);

  gcg_status_sync #(.STAGES(SYNC_STAGES), .RST_VAL(RST_STATUS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (gate_en),
    .q     (gate_status)
  );

  gcg_latch_gate u_cg (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_in      (gate_en),
    .en_latched (en_latched),
    .gated_clk  (gated_clk)
  );

  always_comb begin
    reg_rdata           = '0;
    reg_rdata[STAT_BIT] = gate_status;
    reg_rdata[EN_BIT]   = en_q;
    reg_rdata[SEL_BIT]  = sel_q;
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~USED_MASK) == '0); // R1
  AST_NO_GATE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (KIND == GK_NONE) |-> gate_en); // R3
  AST_HW_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    hw_ctl |-> (gate_en == auto_req)); // R4
  AST_SW_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_ctl && has_en_bit(KIND)) |-> (gate_en == reg_rdata[EN_BIT])); // R5
  AST_HWON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((KIND == GK_HW_OR_ON) && !hw_ctl) |-> gate_en); // R7
  AST_WRITE_LAND: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && has_sel_bit(KIND)) |=> (reg_rdata[SEL_BIT] == $past(reg_wdata[SEL_BIT]))); // R10

endmodule

// File: tb/dual_gate_ctrl_test.sv
module dual_gate_ctrl_test;
  import gcg_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic        auto_req;

  logic [31:0] rd [5];
  logic [4:0]  en_o, st_o, gc_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  dual_gate_ctrl #(.KIND(GK_NONE)) u_none (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(rd[0]), .auto_req(auto_req),
    .gate_en(en_o[0]), .gate_status(st_o[0]), .gated_clk(gc_o[0]));
  dual_gate_ctrl #(.KIND(GK_HW_ONLY)) u_hw (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(rd[1]), .auto_req(auto_req),
    .gate_en(en_o[1]), .gate_status(st_o[1]), .gated_clk(gc_o[1]));
  dual_gate_ctrl #(.KIND(GK_SW_ONLY)) u_sw (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(rd[2]), .auto_req(auto_req),
    .gate_en(en_o[2]), .gate_status(st_o[2]), .gated_clk(gc_o[2]));
  dual_gate_ctrl #(.KIND(GK_SELECTABLE)) uut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(rd[3]), .auto_req(auto_req),
    .gate_en(en_o[3]), .gate_status(st_o[3]), .gated_clk(gc_o[3]));
  dual_gate_ctrl #(.KIND(GK_HW_OR_ON)) u_hwon (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(rd[4]), .auto_req(auto_req),
    .gate_en(en_o[4]), .gate_status(st_o[4]), .gated_clk(gc_o[4]));

  // model state, index: 0 none, 1 hw-only, 2 sw-only, 3 selectable, 4 hw-or-open
  bit m_en [5];
  bit m_sel[5];
  bit h1[5];
  bit h2[5];

  function automatic bit m_open(int k, bit auto_v);
    bit hw;
    hw = (k == 1) || ((k == 3 || k == 4) && m_sel[k]);
    if (k == 0) return 1'b1;
    if (hw)     return auto_v;
    if (k == 4) return 1'b1;
    return m_en[k];
  endfunction

  function automatic logic [31:0] m_read(int k);
    logic [31:0] v = '0;
    v[0] = h2[k];
    v[1] = (k == 2 || k == 3) ? m_en[k] : 1'b0;
    v[2] = (k == 1) ? 1'b1 : ((k == 3 || k == 4) ? m_sel[k] : 1'b0);
    return v;
  endfunction

  function automatic string kind_req(int k);
    case (k)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string rtag);
    for (int k = 0; k < 5; k++) begin
      bit e = m_open(k, auto_req);
      chk(en_o[k] === e, (rtag == "") ? kind_req(k) : rtag, $sformatf("gate_en kind %0d", k),
          32'(en_o[k]), 32'(e));
      chk(st_o[k] === h2[k], "R8", $sformatf("status kind %0d", k), 32'(st_o[k]), 32'(h2[k]));
      chk(rd[k] === m_read(k), "R1", $sformatf("rdata kind %0d", k), rd[k], m_read(k));
      chk(gc_o[k] === 1'b0, "R9", $sformatf("gated clk low kind %0d", k), 32'(gc_o[k]), 32'd0);
    end
  endtask

  task automatic step(input bit mid_toggle);
    bit pre[5];
    for (int k = 0; k < 5; k++) pre[k] = m_open(k, auto_req);
    @(posedge clk);
    for (int k = 0; k < 5; k++) begin
      h2[k] = h1[k];
      h1[k] = pre[k];
      if (reg_wr) begin
        if (k == 2 || k == 3) m_en[k]  = reg_wdata[1];
        if (k == 3 || k == 4) m_sel[k] = reg_wdata[2];
      end
    end
    #1;
    chk(gc_o[3] === pre[3], "R9", "gated clk high phase", 32'(gc_o[3]), 32'(pre[3]));
    if (mid_toggle) begin
      auto_req = ~auto_req;
      #1;
      chk(gc_o[3] === pre[3], "R9", "gated clk held after mid-high change",
          32'(gc_o[3]), 32'(pre[3]));
    end
    @(negedge clk);
    check_all("");
  endtask

  task automatic write_word(input logic [31:0] w);
    reg_wr = 1'b1;
    reg_wdata = w;
    step(1'b0);
    reg_wr = 1'b0;
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed);
    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0; auto_req = 1'b0;
    for (int k = 0; k < 5; k++) begin
      m_en[k] = 1'b1; m_sel[k] = 1'b0;
      h1[k] = (k != 1); h2[k] = (k != 1);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_all("R2");

    // R10: write disables software gates; no effect before the edge
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = 32'h0;
    #1;
    chk(en_o[2] === 1'b1, "R10", "sw gate before edge", 32'(en_o[2]), 32'd1);
    step(1'b0);
    reg_wr = 1'b0;
    chk(en_o[2] === 1'b0, "R10", "sw gate after edge", 32'(en_o[2]), 32'd0);
    step(1'b0);
    step(1'b0);

    // hand selectable and hw-or-open gates to hardware
    write_word(32'h4);
    auto_req = 1'b1; step(1'b0); step(1'b0);
    auto_req = 1'b0; step(1'b0); step(1'b0);
    step(1'b1); step(1'b0); step(1'b1); step(1'b0);

    // back to software, enable set; reserved bits written high
    write_word(32'hFFFF_FFFA);
    step(1'b0); step(1'b0);
    write_word(32'hFFFF_FFF8);
    auto_req = 1'b1; step(1'b0);

    for (int i = 0; i < 500; i++) begin
      reg_wr    = ($urandom % 4) == 0;
      reg_wdata = $urandom;
      auto_req  = $urandom % 2;
      step(($urandom % 8) == 0);
    end
    reg_wr = 1'b0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(5ns * 200000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule